// File: doc/BRIEF.md
# Flash FIFO Streaming Controller

This block moves bulk data between a host register port and a word-organised backing store through one shared 32-bit data FIFO. For a read, the host first obtains ownership of the flash path. It writes a byte start address and then a control word that carries a word count and a read-mode bit. The engine raises busy and fetches that many words into the FIFO, one word every `LAT` cycles. It then drops busy, and the host drains the words by reading the data port once per word.

For a write, the host releases ownership, loads the destination address and pushes words through the same data port. An internal drainer takes over the path and copies each queued word into the store at consecutive word addresses. The control register reports the free FIFO space in words, so software can wait for the FIFO to empty before it pushes the next chunk. Writing zero to the control register ends a transfer phase and clears the sticky error flags.

Top module: `flash_stream_ctrl`

## Requirements
- R1: After reset, CTRL (offset 0) reads as free space = DEPTH in bits [16 +: CW], with busy (bit 1), underflow (bit 2) and overflow (bit 3) clear. OWN (offset 3) reads 0.
- R2: Setting the request bit (OWN bit 0) makes the status field (OWN bits [9:8]) read 1 (host) exactly GRANT_DLY cycles after the write. Clearing the request returns the field to 0 after the same delay.
- R3: A control write with the read-mode bit (bit 0) set is ignored while the host does not own the path. Busy stays low and free space is unchanged.
- R4: An accepted read start of N words (count in CTRL bits [8 +: CW]) keeps busy set for exactly N × LAT cycles.
- R5: Fetched words come from consecutive store words starting at ADDR (offset 1) divided by four. The two low address bits are ignored, and the host pops the words in address order.
- R6: Each read of the data port (offset 2) pops exactly one word, and free space rises by one.
- R7: A pop from an empty FIFO returns 0 and sets the sticky underflow flag. Writing CTRL with bit 0 clear clears the flag.
- R8: A push to a full FIFO is dropped and sets the sticky overflow flag. Free space reads 0, and the dropped word never appears at the data port.
- R9: Words pushed while the host neither requests nor owns the path are written to the store from the ADDR word onward. OWN status reads 2 (engine) while this is in progress, and free space returns to DEPTH once all words are written.
- R10: A data-port write while busy is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at the data offset) |
| reg_addr | input | 2 | Register word offset: 0 CTRL, 1 ADDR, 2 DATA, 3 OWN |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid in the same cycle as reg_rd |

## Verification
The read path is exercised with an 8-word burst at an unaligned byte address and a 3-word burst at a different offset. These show whether the address low bits are dropped, whether words arrive in order, and whether the busy window scales with the count. The write path streams a distinct pattern into the store with ownership released and reads it back, which separates a working drainer from one that loses or reorders words. Extra pushes beyond capacity and pops past empty expose the flag logic and the FIFO bounds. A push made during a burst shows whether host data can slip in among the fetched words.

// File: rtl/fsc_pkg.sv
// Package: register offsets, field positions and the path-owner encoding
// shared by the streaming controller, its checker and its bench.
package fsc_pkg;
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_OWN  = 2'd3;

    localparam int RDMODE_BIT = 0;
    localparam int BUSY_BIT   = 1;
    localparam int UFLOW_BIT  = 2;
    localparam int OFLOW_BIT  = 3;
    localparam int COUNT_LSB  = 8;
    localparam int SPACE_LSB  = 16;
    localparam int REQ_BIT    = 0;
    localparam int OWNER_LSB  = 8;

    typedef enum logic [1:0] {
        OWNER_NONE   = 2'd0,
        OWNER_HOST   = 2'd1,
        OWNER_ENGINE = 2'd2
    } path_owner_e;
endpackage

// File: rtl/fsc_fifo.sv
// fsc_fifo: single-clock word FIFO with occupancy count.
// Assumes DEPTH is a power of two. Pushes when full and pops when empty are
// not performed; the caller observes full/empty to flag them.
module fsc_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] slots [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rptr];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (do_push) slots[wptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/fsc_grant.sv
// fsc_grant: hands the flash path to the host a fixed GRANT_DLY cycles after
// the request rises, and withdraws it the same delay after it falls.
module fsc_grant #(
    parameter int GRANT_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic granted
);
    logic [GRANT_DLY-1:0] pipe;

    generate
        if (GRANT_DLY > 1) begin : g_multi
            // Delay the request through a short shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[GRANT_DLY-2:0], req};
            end
        end else begin : g_single
            // Single-stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= req;
            end
        end
    endgenerate

    assign granted = pipe[GRANT_DLY-1];
endmodule

// File: rtl/fsc_engine.sv
// fsc_engine: word-addressed backing store plus two sequencers. The fetch
// sequencer reads N words into the FIFO at one word per LAT cycles. The
// drainer copies queued words into the store when enabled and busy is low.
// Assumes start is only pulsed while idle with a nonzero count, and that the
// caller gives host pops priority over drainer pops.
module fsc_engine #(
    parameter int DW        = 32,
    parameter int MEM_WORDS = 256,
    parameter int LAT       = 4,
    parameter int CW        = 7,
    localparam int MA_W     = $clog2(MEM_WORDS),
    localparam int LW       = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MA_W-1:0] start_word,
    input  logic [CW-1:0]   start_cnt,
    input  logic            load_wptr,
    input  logic [MA_W-1:0] wptr_val,
    input  logic            drain_en,
    input  logic            fifo_empty,
    input  logic [DW-1:0]   fifo_head,
    input  logic            host_pop,
    output logic            busy,
    output logic            eng_push,
    output logic [DW-1:0]   eng_wdata,
    output logic            eng_pop,
    output logic            drain_act
);
    localparam logic [LW-1:0] LAT_TOP = LW'(LAT - 1);

    logic [DW-1:0]   store [MEM_WORDS];
    logic [MA_W-1:0] fetch_ptr, drain_ptr;
    logic [CW-1:0]   remain;
    logic [LW-1:0]   f_wait, d_wait;

    assign eng_push  = busy && (f_wait == '0);
    assign eng_wdata = store[fetch_ptr];
    assign drain_act = drain_en && !fifo_empty && !busy;
    assign eng_pop   = drain_act && (d_wait == '0) && !host_pop;

    // Fetch sequencer: one word per LAT cycles until the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            fetch_ptr <= '0;
            remain    <= '0;
            f_wait    <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            fetch_ptr <= start_word;
            remain    <= start_cnt;
            f_wait    <= LAT_TOP;
        end else if (busy) begin
            if (f_wait == '0) begin
                fetch_ptr <= fetch_ptr + 1'b1;
                remain    <= remain - 1'b1;
                f_wait    <= LAT_TOP;
                if (remain == CW'(1)) busy <= 1'b0;
            end else begin
                f_wait <= f_wait - 1'b1;
            end
        end
    end

    // Drain pacing: count LAT cycles per stored word while active.
    always_ff @(posedge clk) begin
        if (!rst_n || !drain_act) d_wait <= LAT_TOP;
        else if (eng_pop)         d_wait <= LAT_TOP;
        else if (d_wait != '0)    d_wait <= d_wait - 1'b1;
    end

    // Drain destination pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)         drain_ptr <= '0;
        else if (load_wptr) drain_ptr <= wptr_val;
        else if (eng_pop)   drain_ptr <= drain_ptr + 1'b1;
    end

    // Store write from the drainer.
    always_ff @(posedge clk) begin
        if (eng_pop) store[drain_ptr] <= fifo_head;
    end
endmodule

// File: rtl/flash_stream_ctrl.sv
// flash_stream_ctrl: register front end of the streaming controller.
// Decodes CTRL/ADDR/DATA/OWN, arbitrates the shared FIFO between the host
// and the engine, and keeps the sticky error flags.
// Assumes reg_rd and reg_wr are never both high, and DW >= SPACE_LSB + CW.
module flash_stream_ctrl #(
    parameter int DW        = 32,
    parameter int DEPTH     = 64,
    parameter int MEM_WORDS = 256,
    parameter int LAT       = 4,
    parameter int GRANT_DLY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);
    import fsc_pkg::*;

    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int MA_W = $clog2(MEM_WORDS);

    logic [DW-1:0] addr_reg;
    logic          own_req, host_granted, wr_mode, uflow, oflow;
    logic          wr_ctrl, wr_addr, wr_data, wr_own, rd_data;
    logic          start_ok, flag_clr, host_push, host_pop;
    logic          busy, eng_push, eng_pop, drain_act, drain_en;
    logic [DW-1:0] eng_wdata, fifo_head, fifo_wdata;
    logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [CW-1:0] fifo_cnt, space, req_cnt;
    path_owner_e   owner;

    assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_addr   = reg_wr && (reg_addr == OFS_ADDR);
    assign wr_data   = reg_wr && (reg_addr == OFS_DATA);
    assign wr_own    = reg_wr && (reg_addr == OFS_OWN);
    assign rd_data   = reg_rd && (reg_addr == OFS_DATA);
    assign req_cnt   = reg_wdata[COUNT_LSB +: CW];
    assign start_ok  = wr_ctrl && reg_wdata[RDMODE_BIT] && host_granted
                       && !busy && (req_cnt != '0);
    assign flag_clr  = wr_ctrl && !reg_wdata[RDMODE_BIT];
    assign host_push = wr_data && !busy;
    assign host_pop  = rd_data;
    assign fifo_push = eng_push || host_push;
    assign fifo_wdata = eng_push ? eng_wdata : reg_wdata;
    assign fifo_pop  = host_pop || eng_pop;
    assign drain_en  = wr_mode && !own_req && !host_granted;
    assign space     = CW'(DEPTH) - fifo_cnt;
    assign owner     = host_granted ? OWNER_HOST
                     : (drain_act ? OWNER_ENGINE : OWNER_NONE);

    fsc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
        .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt),
        .full(fifo_full), .empty(fifo_empty)
    );

    fsc_grant #(.GRANT_DLY(GRANT_DLY)) u_grant (
        .clk(clk), .rst_n(rst_n), .req(own_req), .granted(host_granted)
    );

    fsc_engine #(.DW(DW), .MEM_WORDS(MEM_WORDS), .LAT(LAT), .CW(CW)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start_ok),
        .start_word(addr_reg[2 +: MA_W]), .start_cnt(req_cnt),
        .load_wptr(wr_addr), .wptr_val(reg_wdata[2 +: MA_W]),
        .drain_en(drain_en), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .host_pop(host_pop), .busy(busy), .eng_push(eng_push),
        .eng_wdata(eng_wdata), .eng_pop(eng_pop), .drain_act(drain_act)
    );

    // Host-written registers: address, ownership request, write-stream mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_reg <= '0;
            own_req  <= 1'b0;
            wr_mode  <= 1'b0;
        end else begin
            if (wr_addr) addr_reg <= reg_wdata;
            if (wr_own)  own_req  <= reg_wdata[REQ_BIT];
            if (host_push)    wr_mode <= 1'b1;
            else if (wr_ctrl) wr_mode <= 1'b0;
        end
    end

    // Sticky error flags: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uflow <= 1'b0;
            oflow <= 1'b0;
        end else begin
            if (host_pop && fifo_empty)  uflow <= 1'b1;
            else if (flag_clr)           uflow <= 1'b0;
            if (fifo_push && fifo_full)  oflow <= 1'b1;
            else if (flag_clr)           oflow <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[BUSY_BIT]           = busy;
                reg_rdata[UFLOW_BIT]          = uflow;
                reg_rdata[OFLOW_BIT]          = oflow;
                reg_rdata[SPACE_LSB +: CW]    = space;
            end
            OFS_ADDR: reg_rdata = addr_reg;
            OFS_DATA: reg_rdata = fifo_empty ? '0 : fifo_head;
            OFS_OWN: begin
                reg_rdata[REQ_BIT]            = own_req;
                reg_rdata[OWNER_LSB +: 2]     = owner;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fsc_checker.sv
// fsc_checker: temporal properties of the streaming controller, bound to the
// top module. Observes engine, FIFO and grant signals.
module fsc_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          granted,
    input logic          drain_act,
    input logic [CW-1:0] fifo_cnt,
    input logic          fifo_pop,
    input logic          uflow,
    input logic          flag_clr
);
    // R3: a fetch can only begin while the host held the path.
    p_start_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(granted));

    // R8: occupancy never exceeds the FIFO depth.
    p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R8: a full FIFO stays full until a pop.
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CW'(DEPTH) && !fifo_pop) |=> (fifo_cnt == CW'(DEPTH)));

    // R9: the drainer and the host never hold the path together.
    p_owner_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(granted && drain_act));

    // R7: underflow stays set until an explicit clear.
    p_uflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !flag_clr) |=> uflow);
endmodule

bind flash_stream_ctrl fsc_checker #(.DEPTH(DEPTH)) u_fsc_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .granted(host_granted),
    .drain_act(drain_act), .fifo_cnt(fifo_cnt), .fifo_pop(fifo_pop),
    .uflow(uflow), .flag_clr(flag_clr)
);

// File: tb/test_flash_stream_ctrl.sv
// Directed bench for flash_stream_ctrl: one task per scenario.
module test_flash_stream_ctrl;
    localparam int DW = 32, DEPTH = 64, MEM_WORDS = 256, LAT = 4, GRANT_DLY = 3;
    localparam logic [1:0] A_CTRL = 2'd0, A_ADDR = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_stream_ctrl #(.DW(DW), .DEPTH(DEPTH), .MEM_WORDS(MEM_WORDS),
                        .LAT(LAT), .GRANT_DLY(GRANT_DLY)) i_flash_stream_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Each access occupies one cycle, starting and ending just after a negedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] space_of(input logic [31:0] v);
        return (v >> 16) & 32'h7F;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);
        check(v == (DEPTH << 16), "R1 ctrl after reset", v, DEPTH << 16);
        rd(A_OWN, v);
        check(v == 0, "R1 own after reset", v, 0);
    endtask

    task automatic t_start_without_grant();
        logic [31:0] v;
        wr(A_CTRL, (4 << 8) | 1);
        rd(A_CTRL, v);
        check(v == (DEPTH << 16), "R3 start ignored without grant", v, DEPTH << 16);
    endtask

    task automatic t_write_stream();
        logic [31:0] v;
        int guard;
        wr(A_ADDR, 32'h40);
        for (int i = 0; i < 8; i++) wr(A_DATA, 32'hA500_0000 + i);
        rd(A_OWN, v);
        check(((v >> 8) & 3) == 2, "R9 owner shows engine while draining", v, 32'h200);
        guard = 0;
        do begin
            rd(A_CTRL, v);
            guard++;
        end while (space_of(v) != DEPTH && guard < 500);
        check(space_of(v) == DEPTH, "R9 fifo drained to store", space_of(v), DEPTH);
        rd(A_OWN, v);
        check(v == 0, "R9 owner idle after drain", v, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_acquire();
        logic [31:0] v;
        wr(A_OWN, 1);
        for (int i = 0; i < GRANT_DLY; i++) rd(A_OWN, v);
        check(v == 32'h1, "R2 not granted before delay", v, 32'h1);
        rd(A_OWN, v);
        check(v == 32'h101, "R2 granted after delay", v, 32'h101);
    endtask

    task automatic t_burst(input logic [31:0] byte_addr, input int n,
                           input int first_idx, input bit poke_busy);
        logic [31:0] v;
        int busy_cyc, bad;
        wr(A_ADDR, byte_addr);
        wr(A_CTRL, (n << 8) | 1);
        busy_cyc = 0;
        if (poke_busy) begin
            wr(A_DATA, 32'hDEAD_BEEF);
            busy_cyc = 1;
        end
        do begin
            rd(A_CTRL, v);
            if (v[1]) busy_cyc++;
        end while (v[1] && busy_cyc < 2000);
        check(busy_cyc == n * LAT, "R4 busy window", busy_cyc, n * LAT);
        check(space_of(v) == DEPTH - n,
              poke_busy ? "R10 push during busy ignored" : "R6 space after fill",
              space_of(v), DEPTH - n);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            rd(A_DATA, v);
            if (v != 32'hA500_0000 + first_idx + i) begin
                bad++;
                $display("FAIL R5 word %0d: actual 0x%08h expected 0x%08h",
                         i, v, 32'hA500_0000 + first_idx + i);
            end
            if (i == 0) begin
                rd(A_CTRL, v);
                check(space_of(v) == DEPTH - n + 1, "R6 one pop per read",
                      space_of(v), DEPTH - n + 1);
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
        wr(A_CTRL, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        rd(A_DATA, v);
        check(v == 0, "R7 empty pop returns zero", v, 0);
        rd(A_CTRL, v);
        check(v[2] == 1'b1, "R7 underflow flag set", v, (DEPTH << 16) | 4);
        wr(A_CTRL, 0);
        rd(A_CTRL, v);
        check(v == (DEPTH << 16), "R7 flag cleared by zero write", v, DEPTH << 16);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        int bad;
        for (int i = 0; i <= DEPTH; i++) wr(A_DATA, 32'h5A00_0000 + i);
        rd(A_CTRL, v);
        check(v == 32'h8, "R8 full with overflow flag", v, 32'h8);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_DATA, v);
            if (v != 32'h5A00_0000 + i) bad++;
        end
        check(bad == 0, "R8 kept words intact", bad, 0);
        rd(A_DATA, v);
        check(v == 0, "R8 dropped word absent", v, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_release();
        logic [31:0] v;
        wr(A_OWN, 0);
        for (int i = 0; i < GRANT_DLY; i++) rd(A_OWN, v);
        check(v == 32'h100, "R2 grant held until delay", v, 32'h100);
        rd(A_OWN, v);
        check(v == 0, "R2 grant withdrawn", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_without_grant();
        t_write_stream();
        t_acquire();
        t_burst(32'h42, 8, 0, 1'b0);
        t_burst(32'h48, 3, 2, 1'b1);
        t_underflow();
        t_overflow();
        t_release();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule